// File: doc/BRIEF.md
# I2C bit timing generator

This block produces the open-drain SCL and SDA waveforms of an I2C controller, one bus event per command. A sequencer above it asks for a START, a STOP, one written bit or one read bit. The block shapes the pins from the functional clock and answers each command with a one-cycle done pulse. A read command also returns the SDA level it sampled.

Bus timing comes from one 32-bit divider word. Its upper half sets the SCL high phase and its lower half sets the SCL low phase. Each field counts in units of eight functional clocks and has an implied +1. Written data moves halfway through the low phase. A START issued while SCL is already held low becomes a repeated START, and its timing is derived from the high setting alone. The divider word is sampled only when a command is accepted, so software may rewrite it at any time. The pins are only ever pulled low or released. Clock stretching and arbitration are not handled.

Top module: `i2c_bit_timer`

## Requirements
- R1: During and right after reset, both pins are released (scl_oe=0, sda_oe=0), done is 0 and cmd_ready is 1.
- R2: Let L = div_cfg[15:0] and H = div_cfg[31:16], with TL=(L+1)*8 and TH=(H+1)*8 clocks. Take t=0 as the clock edge that accepts a command. For a write, read, STOP from SCL low or repeated START, SCL is pulled low from t=0 and released at t=TL.
- R3: For a write or a read, SCL is pulled low again at t=TL+TH, and done is 1 in exactly that cycle.
- R4: For a write, SDA keeps its previous state until t=TL/2 and then carries the bit: cmd_wbit=0 pulls it low and cmd_wbit=1 releases it.
- R5: For a read, SDA is released from t=TL/2. The line is sampled at the middle of the SCL high phase, and that value is on rd_bit when done pulses.
- R6: A START accepted while SCL is released pulls SDA low at t=0, pulls SCL low at t=TH and pulses done at t=TH.
- R7: A START accepted while SCL is pulled low is a repeated START. SDA is released at t=TL/2 and SCL is released at t=TL. SDA is pulled low at t=TL+7*(H+1). SCL is pulled low, with done, at t=TL+2*TH.
- R8: A STOP accepted while SCL is pulled low pulls SDA low at t=TL/2 and releases SCL at t=TL. It releases SDA, with done, at t=TL+TH.
- R9: A STOP accepted while SCL is released leaves both pins unchanged and pulses done at t=0.
- R10: cmd_op encodes 0=START, 1=STOP, 2=write bit and 3=read bit. A command is accepted when cmd_valid and cmd_ready are both 1. cmd_ready is 1 only between commands, including the cycle in which done pulses. cmd_valid and div_cfg changes while busy do not affect the command in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_cfg | input | 32 | Divider word: high-phase count in [31:16], low-phase count in [15:0] |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code (0 START, 1 STOP, 2 write, 3 read) |
| cmd_wbit | input | 1 | Bit to send with a write command |
| cmd_ready | output | 1 | Generator is idle and will take a command |
| done | output | 1 | One-cycle completion pulse |
| rd_bit | output | 1 | SDA value sampled by the last read |
| sda_in | input | 1 | Readback of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The completion of one command and the acceptance of the next can fall in the same cycle. cmd_ready is high while done pulses. The bench presents every table command at the sample where it expects done, so each command is taken in the previous command's done cycle. The pin timeline of the new command is then compared clock by clock from that edge, with done required in exactly the final cycle. A stray request and a rewritten divider word are also injected while a command is busy, and the unchanged timeline shows that they were ignored.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bt_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } bt_state_e;

  // clocks per divider unit is 2**PRESCALE_LOG2
  localparam int unsigned PRESCALE_LOG2 = 3;

  // length of one SCL phase in functional clocks for a divider field value
  function automatic logic [31:0] phase_len(input logic [31:0] d);
    return (d + 32'd1) << PRESCALE_LOG2;
  endfunction

  // offset into the high phase where a repeated START drops SDA (7/8 of it)
  function automatic logic [31:0] rs_fall_at(input logic [31:0] d);
    return (phase_len(d) >> PRESCALE_LOG2) * 32'd7;
  endfunction

  // SCL high time of a repeated START (two programmed high phases)
  function automatic logic [31:0] rs_high_len(input logic [31:0] d);
    return phase_len(d) << 1;
  endfunction

endpackage

// File: rtl/i2c_bt_divlatch.sv
module i2c_bt_divlatch #(
  parameter  int DIVW = 16,
  localparam int CW   = DIVW + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2*DIVW-1:0] div_cfg,
  output logic [CW-1:0]     t_low_mid,
  output logic [CW-1:0]     t_low_end,
  output logic [CW-1:0]     t_high_mid,
  output logic [CW-1:0]     t_high_end,
  output logic [CW-1:0]     t_rs_sda,
  output logic [CW-1:0]     t_rs_end
);
  import i2c_bt_pkg::*;

  logic [DIVW-1:0] lo_f;
  logic [DIVW-1:0] hi_f;
  assign lo_f = div_cfg[DIVW-1:0];
  assign hi_f = div_cfg[2*DIVW-1:DIVW];

  // compare targets are stored as "last cycle index", i.e. length minus one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_low_mid  <= CW'((phase_len(32'd0) >> 1) - 32'd1);
      t_low_end  <= CW'(phase_len(32'd0) - 32'd1);
      t_high_mid <= CW'((phase_len(32'd0) >> 1) - 32'd1);
      t_high_end <= CW'(phase_len(32'd0) - 32'd1);
      t_rs_sda   <= CW'(rs_fall_at(32'd0) - 32'd1);
      t_rs_end   <= CW'(rs_high_len(32'd0) - 32'd1);
    end else if (load) begin
      t_low_mid  <= CW'((phase_len(32'(lo_f)) >> 1) - 32'd1);
      t_low_end  <= CW'(phase_len(32'(lo_f)) - 32'd1);
      t_high_mid <= CW'((phase_len(32'(hi_f)) >> 1) - 32'd1);
      t_high_end <= CW'(phase_len(32'(hi_f)) - 32'd1);
      t_rs_sda   <= CW'(rs_fall_at(32'(hi_f)) - 32'd1);
      t_rs_end   <= CW'(rs_high_len(32'(hi_f)) - 32'd1);
    end
  end

  // divider only taken at command acceptance
  assert_div_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(t_low_end) && $stable(t_high_end) && $stable(t_rs_end)));

endmodule

// File: rtl/i2c_bt_timebase.sv
module i2c_bt_timebase #(
  parameter int CW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |=> (cnt == $past(cnt) + 1'b1));

  assert_count_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/i2c_bt_events.sv
module i2c_bt_events
  import i2c_bt_pkg::*;
#(
  parameter int CW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bt_state_e     state,
  input  bt_op_e        op,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] t_low_mid,
  input  logic [CW-1:0] t_low_end,
  input  logic [CW-1:0] t_high_mid,
  input  logic [CW-1:0] t_high_end,
  input  logic [CW-1:0] t_rs_sda,
  input  logic [CW-1:0] t_rs_end,
  output logic          ev_low_mid,
  output logic          ev_low_end,
  output logic          ev_hi_mid,
  output logic          ev_rs_sda,
  output logic          ev_hi_end,
  output logic          ev_hold_end
);

  logic in_low, in_high, in_hold, is_rs;
  logic [CW-1:0] hi_target;

  assign in_low    = (state == ST_LOW);
  assign in_high   = (state == ST_HIGH);
  assign in_hold   = (state == ST_HOLD);
  assign is_rs     = (op == OP_START);
  assign hi_target = is_rs ? t_rs_end : t_high_end;

  assign ev_low_mid  = in_low  && (cnt == t_low_mid);
  assign ev_low_end  = in_low  && (cnt == t_low_end);
  assign ev_hi_mid   = in_high && (cnt == t_high_mid);
  assign ev_rs_sda   = in_high && is_rs && (cnt == t_rs_sda);
  assign ev_hi_end   = in_high && (cnt == hi_target);
  assign ev_hold_end = in_hold && (cnt == t_high_end);

  // data change point lies strictly inside the low phase
  assert_mid_before_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_low_mid |-> !ev_low_end);

  // repeated-START SDA fall comes before SCL falls
  assert_rs_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rs_sda |-> !ev_hi_end);

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import i2c_bt_pkg::*;
#(
  parameter  int DIVW = 16,
  localparam int CW   = DIVW + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*DIVW-1:0] div_cfg,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_wbit,
  output logic              cmd_ready,
  output logic              done,
  output logic              rd_bit,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);

  bt_state_e state;
  bt_op_e    op_q;
  bt_op_e    cmd_op_e;
  logic      wbit_q;
  logic      accept;

  logic [CW-1:0] cnt;
  logic [CW-1:0] t_low_mid, t_low_end, t_high_mid, t_high_end, t_rs_sda, t_rs_end;
  logic ev_low_mid, ev_low_end, ev_hi_mid, ev_rs_sda, ev_hi_end, ev_hold_end;

  assign cmd_op_e  = bt_op_e'(cmd_op);
  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  i2c_bt_divlatch #(.DIVW(DIVW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .div_cfg    (div_cfg),
    .t_low_mid  (t_low_mid),
    .t_low_end  (t_low_end),
    .t_high_mid (t_high_mid),
    .t_high_end (t_high_end),
    .t_rs_sda   (t_rs_sda),
    .t_rs_end   (t_rs_end)
  );

  i2c_bt_timebase #(.CW(CW)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept || ev_low_end),
    .run   (state != ST_IDLE),
    .cnt   (cnt)
  );

  i2c_bt_events #(.CW(CW)) u_ev (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .op          (op_q),
    .cnt         (cnt),
    .t_low_mid   (t_low_mid),
    .t_low_end   (t_low_end),
    .t_high_mid  (t_high_mid),
    .t_high_end  (t_high_end),
    .t_rs_sda    (t_rs_sda),
    .t_rs_end    (t_rs_end),
    .ev_low_mid  (ev_low_mid),
    .ev_low_end  (ev_low_end),
    .ev_hi_mid   (ev_hi_mid),
    .ev_rs_sda   (ev_rs_sda),
    .ev_hi_end   (ev_hi_end),
    .ev_hold_end (ev_hold_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_START;
      wbit_q <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
      rd_bit <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q   <= cmd_op_e;
            wbit_q <= cmd_wbit;
            unique case (cmd_op_e)
              OP_START: begin
                if (scl_oe) state <= ST_LOW;
                else begin
                  sda_oe <= 1'b1;
                  state  <= ST_HOLD;
                end
              end
              OP_STOP: begin
                if (scl_oe) state <= ST_LOW;
                else        done  <= 1'b1;
              end
              default: begin
                scl_oe <= 1'b1;
                state  <= ST_LOW;
              end
            endcase
          end
        end
        ST_HOLD: begin
          if (ev_hold_end) begin
            scl_oe <= 1'b1;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_LOW: begin
          if (ev_low_mid) begin
            unique case (op_q)
              OP_STOP:  sda_oe <= 1'b1;
              OP_WRITE: sda_oe <= !wbit_q;
              default:  sda_oe <= 1'b0;
            endcase
          end
          if (ev_low_end) begin
            scl_oe <= 1'b0;
            state  <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (ev_hi_mid && op_q == OP_READ) rd_bit <= sda_in;
          if (ev_rs_sda) sda_oe <= 1'b1;
          if (ev_hi_end) begin
            if (op_q == OP_STOP) sda_oe <= 1'b0;
            else                 scl_oe <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  assert_scl_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_low_end |=> !scl_oe);

  // SDA may only move under a released SCL for START or STOP
  assert_sda_under_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (op_q == OP_START || op_q == OP_STOP));

  assert_read_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH && op_q == OP_READ) |-> !sda_oe);

  assert_high_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hi_end && op_q != OP_STOP) |=> (scl_oe && done));

endmodule

// File: tb/i2c_bit_timer_test.sv
module i2c_bit_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  typedef struct packed {
    logic [1:0]  op;
    logic        wbit;
    logic        slv;
    logic [15:0] lo;
    logic [15:0] hi;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b0, 1'b1, 16'd1, 16'd1},
    '{2'd0, 1'b0, 1'b1, 16'd1, 16'd2},
    '{2'd2, 1'b1, 1'b1, 16'd0, 16'd0},
    '{2'd2, 1'b0, 1'b1, 16'd3, 16'd1},
    '{2'd3, 1'b0, 1'b1, 16'd2, 16'd3},
    '{2'd3, 1'b0, 1'b0, 16'd1, 16'd0},
    '{2'd0, 1'b0, 1'b1, 16'd2, 16'd1},
    '{2'd2, 1'b0, 1'b1, 16'd1, 16'd4},
    '{2'd1, 1'b0, 1'b1, 16'd4, 16'd2},
    '{2'd1, 1'b0, 1'b1, 16'd0, 16'd0},
    '{2'd0, 1'b0, 1'b1, 16'd0, 16'd0},
    '{2'd3, 1'b0, 1'b1, 16'd5, 16'd2},
    '{2'd0, 1'b0, 1'b1, 16'd0, 16'd0},
    '{2'd2, 1'b1, 1'b1, 16'd1, 16'd1},
    '{2'd1, 1'b0, 1'b1, 16'd0, 16'd0},
    '{2'd2, 1'b0, 1'b1, 16'd1, 16'd1},
    '{2'd1, 1'b0, 1'b1, 16'd1, 16'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] div_cfg;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic        cmd_wbit;
  logic        cmd_ready, done, rd_bit;
  logic        sda_in, scl_oe, sda_oe;
  logic        slave_bit;

  int n_chk = 0;
  int n_bad = 0;
  bit m_scl = 1'b0;
  bit m_sda = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-AND of the bus: line is low if the generator or the target pulls it
  assign sda_in = slave_bit & ~sda_oe;

  i2c_bit_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_cfg   (div_cfg),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_wbit  (cmd_wbit),
    .cmd_ready (cmd_ready),
    .done      (done),
    .rd_bit    (rd_bit),
    .sda_in    (sda_in),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int dur_of(input int op, input bit pscl, input int tl, input int th);
    if (op == 0) return pscl ? tl + 2 * th : th;
    if (op == 1) return pscl ? tl + th : 0;
    return tl + th;
  endfunction

  // expected {scl_oe, sda_oe} t cycles after acceptance
  function automatic logic [1:0] exp_pins(input int op, input bit wb, input bit pscl,
                                          input bit psda, input int tl, input int th,
                                          input int t);
    bit s, d;
    if (op == 0 && !pscl) begin
      s = (t >= th);
      d = 1'b1;
    end else if (op == 0) begin
      s = (t < tl) || (t >= tl + 2 * th);
      d = (t < tl / 2) ? psda : (t >= tl + (th / 8) * 7);
    end else if (op == 1 && !pscl) begin
      s = pscl;
      d = psda;
    end else if (op == 1) begin
      s = (t < tl);
      d = (t < tl / 2) ? psda : (t < tl + th);
    end else begin
      s = (t < tl) || (t >= tl + th);
      d = (t < tl / 2) ? psda : ((op == 2) ? !wb : 1'b0);
    end
    return {s, d};
  endfunction

  function automatic string tag_of(input int op, input bit pscl);
    case (op)
      0:       return pscl ? "R7" : "R6";
      1:       return pscl ? "R8 R2" : "R9";
      2:       return "R4 R2";
      default: return "R5 R2";
    endcase
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL all watchdog expired: got 0 expected 1");
    finish_run();
  end

  initial begin : main
    div_cfg   = '0;
    cmd_valid = 1'b0;
    cmd_op    = 2'd0;
    cmd_wbit  = 1'b0;
    slave_bit = 1'b1;

    // R1: reset state
    repeat (3) @(negedge clk);
    check({scl_oe, sda_oe, done, cmd_ready} == 4'b0001, "R1", "outputs in reset",
          int'({scl_oe, sda_oe, done, cmd_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check({scl_oe, sda_oe, done, cmd_ready} == 4'b0001, "R1", "outputs after reset",
          int'({scl_oe, sda_oe, done, cmd_ready}), 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int tl, th, d, op, bad_t;
      bit mism, dmis, pscl, psda;
      logic [1:0] ex, got_w, exp_w;
      v    = VECS[i];
      op   = int'(v.op);
      tl   = 8 * (int'(v.lo) + 1);
      th   = 8 * (int'(v.hi) + 1);
      pscl = m_scl;
      psda = m_sda;
      d    = dur_of(op, pscl, tl, th);
      mism = 1'b0;
      dmis = 1'b0;
      bad_t = 0;
      got_w = 2'b00;
      exp_w = 2'b00;

      div_cfg   = {v.hi, v.lo};
      cmd_op    = v.op;
      cmd_wbit  = v.wbit;
      slave_bit = v.slv;
      cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;

      for (int t = 0; t <= d; t++) begin
        if (t > 0) @(negedge clk);
        ex = exp_pins(op, v.wbit, pscl, psda, tl, th, t);
        if ({scl_oe, sda_oe} != ex && !mism) begin
          mism  = 1'b1;
          bad_t = t;
          got_w = {scl_oe, sda_oe};
          exp_w = ex;
        end
        if ((done != (t == d) || cmd_ready != (t == d)) && !dmis) begin
          dmis  = 1'b1;
          bad_t = t;
        end
        // R10: disturb the busy generator with a new divider and a stray request
        if (d > 4 && t == 2) div_cfg = 32'h0003_0002;
        if (d > 4 && t == 3) begin
          cmd_valid = 1'b1;
          cmd_op    = 2'd0;
        end
        if (d > 4 && t == 4) cmd_valid = 1'b0;
      end

      check(!mism, {tag_of(op, pscl), " R10"},
            $sformatf("row %0d pins {scl,sda} at t=%0d", i, bad_t),
            int'(got_w), int'(exp_w));
      check(!dmis, "R3 R10", $sformatf("row %0d done/ready timing, t=%0d", i, bad_t),
            int'(dmis), 0);
      if (op == 3)
        check(rd_bit == v.slv, "R5", $sformatf("row %0d read bit", i),
              int'(rd_bit), int'(v.slv));

      case (op)
        0: begin m_scl = 1'b1; m_sda = 1'b1; end
        1: if (pscl) begin m_scl = 1'b0; m_sda = 1'b0; end
        2: begin m_scl = 1'b1; m_sda = !v.wbit; end
        default: begin m_scl = 1'b1; m_sda = 1'b0; end
      endcase
    end

    // R1: reset in the middle of a write returns to the released state
    div_cfg   = {16'd3, 16'd3};
    cmd_op    = 2'd2;
    cmd_wbit  = 1'b0;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    check(scl_oe == 1'b1 && sda_oe == 1'b1, "R4", "pins before mid-command reset",
          int'({scl_oe, sda_oe}), 3);
    rst_n = 1'b0;
    @(negedge clk);
    check({scl_oe, sda_oe, done, cmd_ready} == 4'b0001, "R1", "outputs after mid-command reset",
          int'({scl_oe, sda_oe, done, cmd_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: STOP on a released bus right after reset
    div_cfg   = {16'd0, 16'd0};
    cmd_op    = 2'd1;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check({scl_oe, sda_oe, done} == 3'b001, "R9", "idle STOP after reset",
          int'({scl_oe, sda_oe, done}), 1);
    @(negedge clk);
    check(done == 1'b0, "R9", "idle STOP done is one cycle", int'(done), 0);

    finish_run();
  end

endmodule